// File: doc/BRIEF.md
# Transmit Inter-Packet Gap Controller

This block sits between a transmit frame source and a 64-bit transmit path that carries eight octets per beat. It holds back the next frame until enough idle octets have passed after the last beat of the frame just sent. The source presents beats with `frmValid`. It marks the final beat with `frmEnd` and gives that beat's valid octet count on `frmBytes`. A beat is taken on every clock edge where `frmValid` and `frmReady` are both high.

Only the low six bits of `gapCfg` set the gap, and `wanMode` selects how they are read. In LAN mode the setting is an idle octet count, forced to a multiple of four. In WAN mode the setting is a stretch divisor: the gap is a base of 12 octets plus one extra octet for every (setting+1) octets of frame sent. The fractional part carries over from frame to frame, so a larger setting gives a shorter gap.

The block also keeps a small deficit credit. A gap may end up to three octets short, and the shortfall is paid back on later gaps.

Top module: `ipg_gap_ctrl`

## Requirements
- R1: `frmReady` is low during reset and in every cycle where `txEnable` is low. It goes high in the cycle after `txEnable` is first seen high at a clock edge.
- R2: After a beat with `frmEnd` high is taken, `frmReady` is low in the next cycle. No beat is taken until it rises again.
- R3: The gap lasts k cycles (k ≥ 1), where k is the smallest value with tail + 8k + (3 − credit) ≥ need. Here tail = 8 − n, where n is the valid octet count of the last beat (`frmBytes` = 0 means 8). need is the required gap in octets.
- R4: LAN need uses only `gapCfg[5:0]`; bits 9:6 have no effect. A setting below 8 becomes 8. Any other setting is rounded to the nearest multiple of four, with a remainder of 2 rounding up. The result is capped at 100.
- R5: When a gap closes with total idle T = tail + 8k, let e = T − need. If e < 0, the credit grows by −e. Otherwise the credit becomes max(credit − e, 0). The credit stays within 0..3 and changes only when a gap closes or the block is disabled.
- R6: In WAN mode, need = 12 + ⌊(r + L)/d⌋, where L is the frame length in octets, d = setting + 1 and r is the remainder left by earlier WAN frames. The new remainder is (r + L) mod d. The remainder does not change on beats sent in LAN mode.
- R7: In WAN mode, a setting below 4 is used as 4 and a setting above 15 is used as 15.
- R8: A cycle with `txEnable` low clears the credit, the WAN remainder and any gap in progress.
- R9: For the same frame, a larger WAN setting gives a gap that is no longer, and here strictly shorter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmitter enable; low clears the gap state |
| wanMode | input | 1 | 1 = WAN stretch reading of the setting, 0 = LAN octet count |
| gapCfg | input | 10 | Gap setting register; bits 5:0 are used |
| frmValid | input | 1 | Source has a beat to send |
| frmEnd | input | 1 | This beat is the last one of the frame |
| frmBytes | input | 3 | Valid octets in the last beat, 0 meaning all eight |
| frmReady | output | 1 | Beat may be taken this cycle |

## Verification
The assertions assume that `gapCfg` and `wanMode` hold steady from the first beat of a frame through its gap. They also assume that `frmBytes` is meaningful only on the beat that carries `frmEnd`. The stimulus changes the setting and the mode only while no frame is in flight. It toggles `txEnable` only between frames, so every gap starts from a settled setting. A behavioural model predicts `frmReady` on every cycle. Hand-computed gap lengths cover the rounding, clamping, credit and remainder cases.

// File: rtl/ipg_pkg.sv
`timescale 1ns/1ps
package ipg_pkg;
  localparam int BEAT_OCTETS = 8;
  localparam int BYTE_W      = $clog2(BEAT_OCTETS);
  localparam int CREDIT_MAX  = 3;
  localparam int CR_W        = $clog2(CREDIT_MAX + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // disable: wipe all gap state
    logic beat;    // a beat is taken this cycle
    logic last;    // the taken beat ends the frame
    logic tick;    // one idle beat passes inside a gap
  } ipgStrobe_t;

  typedef enum logic [1:0] {ST_OFF, ST_OPEN, ST_GAP} ipgState_t;
endpackage

// File: rtl/ipg_ctrl.sv
`timescale 1ns/1ps
module ipg_ctrl
  import ipg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       frmValid,
  input  logic       frmEnd,
  input  logic       gapMet,
  output ipgStrobe_t strobe,
  output logic       frmReady,
  output logic       gapOn
);
  ipgState_t stateQ, stateD;

  assign frmReady = (stateQ == ST_OPEN) && txEnable;
  assign gapOn    = (stateQ == ST_GAP);

  always_comb begin
    strobe       = '0;
    stateD       = stateQ;
    strobe.clear = !txEnable;
    if (!txEnable) begin
      stateD = ST_OFF;
    end else begin
      case (stateQ)
        ST_OFF:  stateD = ST_OPEN;
        ST_OPEN: begin
          strobe.beat = frmValid;
          strobe.last = frmValid && frmEnd;
          if (frmValid && frmEnd) stateD = ST_GAP;
        end
        ST_GAP: begin
          strobe.tick = 1'b1;
          if (gapMet) stateD = ST_OPEN;
        end
        default: stateD = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/ipg_datapath.sv
`timescale 1ns/1ps
module ipg_datapath
  import ipg_pkg::*;
#(
  parameter int SET_W    = 6,
  parameter int CNT_W    = 16,
  parameter int LAN_MIN  = 8,
  parameter int LAN_MAX  = 100,
  parameter int WAN_MIN  = 4,
  parameter int WAN_MAX  = 15,
  parameter int WAN_BASE = 12,
  parameter int REM_W    = $clog2(WAN_MAX + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  ipgStrobe_t        strobe,
  input  logic              wanMode,
  input  logic [SET_W-1:0]  gapSet,
  input  logic [BYTE_W-1:0] frmBytes,
  output logic              gapMet,
  output logic [CR_W-1:0]   creditQ,
  output logic [REM_W-1:0]  remQ,
  output logic [CNT_W-1:0]  needQ
);
  localparam int DIV_W = $clog2(WAN_MAX + 2);
  localparam int SUM_W = DIV_W + 1;
  localparam int OCT_W = BYTE_W + 1;
  localparam int QUO_N = (WAN_MAX + BEAT_OCTETS) / (WAN_MIN + 1) + 1;
  localparam int QUO_W = $clog2(QUO_N + 1);
  localparam int LAN_W = SET_W + 2;
  localparam int NW    = CNT_W + 1;

  logic [CNT_W-1:0] accQ, extraQ;

  // LAN reading: clamp low, round to a multiple of four, clamp high
  logic [LAN_W-1:0] lanLo, lanRnd, lanGap;
  always_comb begin
    lanLo = LAN_W'(gapSet);
    if (lanLo < LAN_W'(LAN_MIN)) lanLo = LAN_W'(LAN_MIN);
    lanRnd = (lanLo + LAN_W'(2)) & ~LAN_W'(3);
    lanGap = (lanRnd > LAN_W'(LAN_MAX)) ? LAN_W'(LAN_MAX) : lanRnd;
  end

  // WAN reading: clamped stretch setting, divisor is setting plus one
  logic [SET_W-1:0] wanSet;
  logic [DIV_W-1:0] wanDiv;
  always_comb begin
    if (gapSet < SET_W'(WAN_MIN))      wanSet = SET_W'(WAN_MIN);
    else if (gapSet > SET_W'(WAN_MAX)) wanSet = SET_W'(WAN_MAX);
    else                               wanSet = gapSet;
    wanDiv = DIV_W'(wanSet) + DIV_W'(1);
  end

  // octets carried by the beat being taken
  logic [OCT_W-1:0] beatOct;
  assign beatOct = (strobe.last && frmBytes != '0) ? OCT_W'(frmBytes)
                                                   : OCT_W'(BEAT_OCTETS);

  // small divider: remainder plus beat octets over the stretch divisor
  logic [SUM_W-1:0] rest;
  logic [QUO_W-1:0] quo;
  always_comb begin
    rest = SUM_W'(remQ) + SUM_W'(beatOct);
    quo  = '0;
    for (int i = 0; i < QUO_N; i++) begin
      if (rest >= SUM_W'(wanDiv)) begin
        rest = rest - SUM_W'(wanDiv);
        quo  = quo + QUO_W'(1);
      end
    end
  end

  // gap closing test and credit settlement
  logic [NW-1:0]   accNext, reach, needExt, overV, shortV;
  logic [CR_W-1:0] creditNext;
  always_comb begin
    accNext = {1'b0, accQ} + NW'(BEAT_OCTETS);
    needExt = {1'b0, needQ};
    reach   = accNext + NW'(CREDIT_MAX) - NW'(creditQ);
    gapMet  = reach >= needExt;
    overV   = accNext - needExt;
    shortV  = needExt - accNext;
    if (accNext >= needExt)
      creditNext = (overV >= NW'(creditQ)) ? '0 : creditQ - CR_W'(overV);
    else
      creditNext = creditQ + CR_W'(shortV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0; needQ <= '0; extraQ <= '0; remQ <= '0; creditQ <= '0;
    end else if (strobe.clear) begin
      accQ <= '0; needQ <= '0; extraQ <= '0; remQ <= '0; creditQ <= '0;
    end else begin
      if (strobe.beat && wanMode) begin
        remQ   <= rest[REM_W-1:0];
        extraQ <= extraQ + CNT_W'(quo);
      end
      if (strobe.last) begin
        needQ  <= wanMode ? CNT_W'(WAN_BASE) + extraQ + CNT_W'(quo)
                          : CNT_W'(lanGap);
        accQ   <= CNT_W'(BEAT_OCTETS) - CNT_W'(beatOct);
        extraQ <= '0;
      end
      if (strobe.tick) begin
        if (gapMet) creditQ <= creditNext;
        else        accQ    <= accNext[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ipg_gap_ctrl.sv
`timescale 1ns/1ps
module ipg_gap_ctrl
  import ipg_pkg::*;
#(
  parameter int GAP_W    = 10,
  parameter int SET_W    = 6,
  parameter int CNT_W    = 16,
  parameter int LAN_MIN  = 8,
  parameter int LAN_MAX  = 100,
  parameter int WAN_MIN  = 4,
  parameter int WAN_MAX  = 15,
  parameter int WAN_BASE = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              wanMode,
  input  logic [GAP_W-1:0]  gapCfg,
  input  logic              frmValid,
  input  logic              frmEnd,
  input  logic [BYTE_W-1:0] frmBytes,
  output logic              frmReady
);
  localparam int REM_W = $clog2(WAN_MAX + 1);

  ipgStrobe_t       strobe;
  logic             gapMet, gapOn;
  logic [CR_W-1:0]  creditQ;
  logic [REM_W-1:0] remQ;
  logic [CNT_W-1:0] needQ;
  logic             unusedCfg;

  assign unusedCfg = ^gapCfg[GAP_W-1:SET_W];

  ipg_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .frmValid(frmValid),
    .frmEnd(frmEnd), .gapMet(gapMet), .strobe(strobe),
    .frmReady(frmReady), .gapOn(gapOn)
  );

  ipg_datapath #(
    .SET_W(SET_W), .CNT_W(CNT_W), .LAN_MIN(LAN_MIN), .LAN_MAX(LAN_MAX),
    .WAN_MIN(WAN_MIN), .WAN_MAX(WAN_MAX), .WAN_BASE(WAN_BASE), .REM_W(REM_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wanMode(wanMode),
    .gapSet(gapCfg[SET_W-1:0]), .frmBytes(frmBytes), .gapMet(gapMet),
    .creditQ(creditQ), .remQ(remQ), .needQ(needQ)
  );
endmodule

// File: rtl/ipg_gap_chk.sv
`timescale 1ns/1ps
module ipg_gap_chk #(
  parameter int CNT_W   = 16,
  parameter int REM_W   = 4,
  parameter int CR_W    = 2,
  parameter int LAN_MIN = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             txEnable,
  input logic             wanMode,
  input logic             frmValid,
  input logic             frmEnd,
  input logic             frmReady,
  input logic             gapOn,
  input logic [CR_W-1:0]  creditQ,
  input logic [REM_W-1:0] remQ,
  input logic [CNT_W-1:0] needQ
);
  // R1
  off_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> !frmReady);

  // R2
  end_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmEnd && frmReady) |=> !frmReady);

  // R2
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapOn |-> !frmReady);

  // R4
  need_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapOn |-> (needQ >= CNT_W'(LAN_MIN)));

  // R5
  credit_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(creditQ) |-> ($fell(gapOn) || $past(!txEnable)));

  // R6
  lan_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!wanMode) && $past(txEnable)) |-> $stable(remQ));

  // R8
  off_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!txEnable) |-> (creditQ == '0 && remQ == '0 && !gapOn));
endmodule

bind ipg_gap_ctrl ipg_gap_chk #(
  .CNT_W(CNT_W), .REM_W(REM_W), .CR_W(ipg_pkg::CR_W), .LAN_MIN(LAN_MIN)
) u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .wanMode(wanMode),
  .frmValid(frmValid), .frmEnd(frmEnd), .frmReady(frmReady), .gapOn(gapOn),
  .creditQ(creditQ), .remQ(remQ), .needQ(needQ)
);

// File: tb/test_ipg_gap_ctrl.sv
`timescale 1ns/1ps
module test_ipg_gap_ctrl;
  logic       clk = 1'b0;
  logic       rstN, txEnable, wanMode, frmValid, frmEnd, frmReady;
  logic [9:0] gapCfg;
  logic [2:0] frmBytes;

  int checks = 0, errors = 0;
  // behavioural model state
  bit mOn, mGap;
  int mAcc, mNeed, mCredit, mRem, mExtra;

  always #2.5 clk = ~clk;

  ipg_gap_ctrl i_ipg_gap_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wanMode(wanMode),
    .gapCfg(gapCfg), .frmValid(frmValid), .frmEnd(frmEnd),
    .frmBytes(frmBytes), .frmReady(frmReady)
  );

  function automatic int lanNeed(int cfg);
    int v = cfg % 64;
    if (v < 8) v = 8;
    v = ((v + 2) / 4) * 4;
    if (v > 100) v = 100;
    return v;
  endfunction

  function automatic int wanDivisor(int cfg);
    int v = cfg % 64;
    if (v < 4) v = 4;
    if (v > 15) v = 15;
    return v + 1;
  endfunction

  function automatic bit mRdy();
    return rstN && txEnable && mOn && !mGap;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // advance one clock: update the model from the inputs, then compare
  task automatic tick();
    int oct, d, tot, e;
    if (!rstN || !txEnable) begin
      mOn = 0; mGap = 0; mCredit = 0; mRem = 0; mExtra = 0; mAcc = 0; mNeed = 0;
    end else if (!mOn) begin
      mOn = 1;
    end else if (mGap) begin
      tot = mAcc + 8;
      if (tot + 3 - mCredit >= mNeed) begin
        mGap = 0;
        e = tot - mNeed;
        if (e < 0) mCredit = mCredit - e;
        else mCredit = (mCredit > e) ? mCredit - e : 0;
      end else mAcc = tot;
    end else if (frmValid) begin
      oct = (frmEnd && frmBytes != 0) ? int'(frmBytes) : 8;
      if (wanMode) begin
        d = wanDivisor(int'(gapCfg));
        mExtra = mExtra + (mRem + oct) / d;
        mRem = (mRem + oct) % d;
      end
      if (frmEnd) begin
        mNeed = wanMode ? 12 + mExtra : lanNeed(int'(gapCfg));
        mExtra = 0;
        mAcc = 8 - oct;
        mGap = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(!txEnable ? "R1 ready" : (wanMode ? "R6 ready" : "R3 ready"),
          int'(frmReady), int'(mRdy()));
  endtask

  // send one frame from a ready state and count the gap cycles
  task automatic runFrame(int beats, int lastBytes, output int low);
    for (int i = 0; i < beats; i++) begin
      frmValid = 1; frmEnd = (i == beats - 1); frmBytes = 3'(lastBytes);
      while (!frmReady) tick();
      tick();
    end
    frmValid = 0; frmEnd = 0; frmBytes = 0;
    low = 0;
    while (!frmReady && low < 300) begin low++; tick(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int g;
    rstN = 0; txEnable = 0; wanMode = 0; gapCfg = 10'd12;
    frmValid = 0; frmEnd = 0; frmBytes = 0;
    @(negedge clk);
    tick(); tick();
    check("R1 ready low in reset", int'(frmReady), 0);
    rstN = 1; tick();
    check("R1 ready low while disabled", int'(frmReady), 0);
    txEnable = 1; tick();
    check("R1 ready high after enable", int'(frmReady), 1);

    // LAN, setting 12
    runFrame(3, 0, g); check("R3 full last beat gap", g, 2);
    check("R2 ready dropped after end", int'(g >= 1), 1);
    runFrame(3, 4, g); check("R3 half last beat gap", g, 1);
    runFrame(3, 5, g); check("R5 credit to 1", g, 1);
    runFrame(3, 5, g); check("R5 credit to 2", g, 1);
    runFrame(3, 5, g); check("R5 credit to 3", g, 1);
    runFrame(3, 5, g); check("R5 credit exhausted", g, 2);

    // LAN setting reading
    gapCfg = 10'h3C5; runFrame(2, 0, g); check("R4 low clamp to 8", g, 1);
    gapCfg = 10'h3CC; runFrame(2, 0, g); check("R4 upper bits ignored", g, 2);
    gapCfg = 10'd14;  runFrame(2, 4, g); check("R4 14 rounds to 16", g, 2);
    gapCfg = 10'd13;  runFrame(2, 4, g); check("R4 13 rounds to 12", g, 1);
    gapCfg = 10'd63;  runFrame(2, 0, g); check("R4 63 rounds to 64", g, 8);

    // disable clears the credit
    gapCfg = 10'd12;
    runFrame(2, 5, g); runFrame(2, 5, g); runFrame(2, 5, g);
    txEnable = 0; tick(); tick();
    check("R1 ready low after disable", int'(frmReady), 0);
    txEnable = 1; tick();
    runFrame(2, 5, g); check("R8 credit cleared by disable", g, 1);

    // WAN, starting from a clean state
    txEnable = 0; tick(); txEnable = 1; tick();
    wanMode = 1;
    gapCfg = 10'd12; runFrame(40, 0, g); check("R6 stretch 13 gap", g, 5);
    gapCfg = 10'd15; runFrame(40, 0, g); check("R9 larger setting shorter", g, 4);
    gapCfg = 10'd4;  runFrame(40, 0, g); check("R6 stretch 5 with carry", g, 10);
    gapCfg = 10'd2;  runFrame(40, 0, g); check("R7 clamp up to 4", g, 10);
    gapCfg = 10'd63; runFrame(40, 0, g); check("R7 clamp down to 15", g, 4);

    // mixed sequence, compared to the model every cycle
    for (int n = 0; n < 40; n++) begin
      wanMode = n[1];
      gapCfg = 10'((n * 23 + 5) % 1024);
      runFrame(1 + (n % 7), n % 8, g);
      if (n % 13 == 12) begin txEnable = 0; tick(); txEnable = 1; tick(); end
    end
    tick(); tick();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule